// File: doc/BRIEF.md
# Asymmetric Multi-Slot Instruction Decoder

This decode stage looks at up to four pre-decoded instructions at the head of an aligned instruction queue and turns them into a stream of micro-ops, at most four per cycle. Each instruction arrives with its byte length (1 to 15) and its micro-op count (1 to 15), both already worked out by pre-decode. The slots are not all the same. Slot 0 is the only complex slot, and it takes the oldest instruction whatever its count is from 1 to 4. The three simple slots behind it only take instructions that produce exactly one micro-op. An instruction that needs more than four micro-ops goes to an internal microcode sequencer. The sequencer then feeds its micro-ops through the same output, at up to four per cycle, until the instruction is finished.

The output side is valid/ready. `out_valid` means the lanes hold `out_num` micro-ops. Nothing advances unless `out_ready` is high in that cycle: no instruction is consumed, the sequencer does not start, and it does not step. The input side is a queue window. `in_cnt` gives how many head entries are present. The queue's acceptance is reported through `take_cnt` and `take_bytes`, so the queue can move its head pointer by entries and by bytes. Every output is a combinational function of the queue window and the sequencer state. Only the sequencer holds registers.

Top module: `asym_decoder`

## Requirements
- R1: While `rst_n` is low and for the first cycle after it, the sequencer is idle. With `in_cnt` = 0 the block shows `out_valid` = 0, `take_cnt` = 0 and `take_bytes` = 0.
- R2: When the oldest instruction needs 1 to 4 micro-ops, it is decoded in slot 0. Its micro-ops fill lanes 0 to m-1, each lane carrying that instruction's tag and sub-index 0 to m-1. Lane L uses bits [L*8 +: 8] of `out_tag` and bits [L*4 +: 4] of `out_sub`.
- R3: A younger instruction joins the group only if its micro-op count is exactly 1. The first younger instruction with a larger count closes the group, and it waits for a later cycle, when it is the oldest.
- R4: When `out_valid` is high, `out_num` is between 1 and 4. A simple instruction joins only while fewer than four micro-ops have been placed. Lanes at or above `out_num` read zero.
- R5: Decode is in program order. Once an instruction is not placed, no younger instruction is placed in that cycle. The lanes after the oldest instruction's micro-ops hold the simple instructions in queue order, with sub-index 0.
- R6: When the oldest instruction needs more than 4 micro-ops and the sequencer is idle, `out_valid` is 0 that cycle. If `out_ready` is high, the instruction is handed to the sequencer, and the block reports `take_cnt` = 1 and `take_bytes` equal to its length.
- R7: While the sequencer is busy, `out_valid` is 1 and `take_cnt` is 0. Each accepted cycle carries min(4, remaining) micro-ops with the handed-off tag and with sub-indices that continue from the previous cycle. Normal decode resumes in the cycle after the last chunk is accepted.
- R8: While `out_ready` is 0, `take_cnt` and `take_bytes` are 0, the sequencer state does not change, and with the same queue window the outputs repeat in the next cycle.
- R9: On an accepted group, `take_cnt` equals the number of instructions placed and `take_bytes` equals the sum of their lengths.
- R10: Only the first `in_cnt` entries are considered. Entry i uses bits [i*8 +: 8] of `in_tag`, [i*4 +: 4] of `in_nuop` and [i*4 +: 4] of `in_len`. With `in_cnt` = 0 and the sequencer idle, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_cnt | input | 3 | Number of valid head entries in the queue window (0 to 4) |
| in_tag | input | 32 | Per-entry instruction tag, entry 0 oldest |
| in_nuop | input | 16 | Per-entry micro-op count (1 to 15) |
| in_len | input | 16 | Per-entry byte length (1 to 15) |
| take_cnt | output | 3 | Entries consumed from the queue this cycle |
| take_bytes | output | 6 | Bytes consumed from the queue this cycle |
| out_valid | output | 1 | Lanes hold micro-ops |
| out_ready | input | 1 | Downstream accepts the lanes this cycle |
| out_num | output | 3 | Number of occupied lanes (1 to 4 when valid) |
| out_tag | output | 32 | Per-lane source instruction tag |
| out_sub | output | 16 | Per-lane micro-op index within its instruction |

## Verification
Two functions can land in the same cycle: back-pressure, and the sequencer's final chunk or its hand-off. When `out_ready` drops exactly as the last chunk of a long instruction is shown, both the drain and the return to normal decode have to wait together. When it drops as a long instruction reaches the head, the hand-off must not happen. Directed runs of long instructions, mixed with a ready signal that is low on a fixed pattern and then at random, create these collisions. A behavioural queue model in the bench predicts every lane, count and take value on every clock.

// File: rtl/asd_pkg.sv
package asd_pkg;
  typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_e;
endpackage

// File: rtl/asd_steer.sv
module asd_steer #(
  parameter int NSLOT = 4,
  parameter int MAXC  = 4,
  parameter int CNT_W = 4,
  parameter int LEN_W = 4
) (
  input  logic                                  enable,
  input  logic [$clog2(NSLOT+1)-1:0]            avail,
  input  logic [NSLOT*CNT_W-1:0]                nuop,
  input  logic [NSLOT*LEN_W-1:0]                len,
  output logic                                  divert,
  output logic [$clog2(NSLOT+1)-1:0]            grp_uops,
  output logic [$clog2(NSLOT+1)-1:0]            grp_insts,
  output logic [LEN_W+$clog2(NSLOT)-1:0]        grp_bytes
);
  localparam int LCW    = $clog2(NSLOT+1);
  localparam int BYTE_W = LEN_W + $clog2(NSLOT);

  always_comb begin
    int   used;
    int   cnt;
    int   bytes;
    logic open_q;
    divert = 1'b0;
    used   = 0;
    cnt    = 0;
    bytes  = 0;
    open_q = 1'b0;
    if (enable && avail != '0) begin
      if (int'(nuop[CNT_W-1:0]) > MAXC) begin
        divert = 1'b1;
      end else begin
        used   = int'(nuop[CNT_W-1:0]);
        cnt    = 1;
        bytes  = int'(len[LEN_W-1:0]);
        open_q = 1'b1;
        for (int i = 1; i < NSLOT; i++) begin
          if (open_q && i < int'(avail) &&
              nuop[i*CNT_W +: CNT_W] == CNT_W'(1) && used < NSLOT) begin
            used  = used + 1;
            cnt   = cnt + 1;
            bytes = bytes + int'(len[i*LEN_W +: LEN_W]);
          end else begin
            open_q = 1'b0;
          end
        end
      end
    end
    grp_uops  = LCW'(used);
    grp_insts = LCW'(cnt);
    grp_bytes = BYTE_W'(bytes);
  end
endmodule

// File: rtl/asd_lanes.sv
module asd_lanes #(
  parameter int NSLOT = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input  logic                           seq_busy,
  input  logic [TAG_W-1:0]               seq_tag,
  input  logic [CNT_W-1:0]               seq_base,
  input  logic [$clog2(NSLOT+1)-1:0]     num,
  input  logic [CNT_W-1:0]               lead,
  input  logic [NSLOT*TAG_W-1:0]         in_tag,
  output logic [NSLOT*TAG_W-1:0]         lane_tag,
  output logic [NSLOT*CNT_W-1:0]         lane_sub
);
  logic [TAG_W-1:0] t_arr [NSLOT];
  logic [CNT_W-1:0] s_arr [NSLOT];

  for (genvar L = 0; L < NSLOT; L++) begin : g_lane
    always_comb begin
      int idx;
      t_arr[L] = '0;
      s_arr[L] = '0;
      idx = L - int'(lead) + 1;
      if (L < int'(num)) begin
        if (seq_busy) begin
          t_arr[L] = seq_tag;
          s_arr[L] = seq_base + CNT_W'(L);
        end else if (L < int'(lead)) begin
          t_arr[L] = in_tag[TAG_W-1:0];
          s_arr[L] = CNT_W'(L);
        end else if (idx >= 1 && idx < NSLOT) begin
          t_arr[L] = in_tag[idx*TAG_W +: TAG_W];
        end
      end
    end
    assign lane_tag[L*TAG_W +: TAG_W] = t_arr[L];
    assign lane_sub[L*CNT_W +: CNT_W] = s_arr[L];
  end
endmodule

// File: rtl/asd_useq.sv
module asd_useq
  import asd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [TAG_W-1:0]            load_tag,
  input  logic [CNT_W-1:0]            load_cnt,
  input  logic                        advance,
  output logic                        busy,
  output logic [TAG_W-1:0]            tag,
  output logic [CNT_W-1:0]            base,
  output logic [CNT_W-1:0]            rem,
  output logic [$clog2(NSLOT+1)-1:0]  num
);
  localparam int LCW = $clog2(NSLOT+1);

  sq_state_e        st_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] base_q;

  assign busy = (st_q == SQ_RUN);
  assign tag  = tag_q;
  assign base = base_q;
  assign rem  = rem_q;
  assign num  = (int'(rem_q) > NSLOT) ? LCW'(NSLOT) : LCW'(rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      tag_q  <= '0;
      rem_q  <= '0;
      base_q <= '0;
    end else if (st_q == SQ_IDLE) begin
      if (load) begin
        st_q   <= SQ_RUN;
        tag_q  <= load_tag;
        rem_q  <= load_cnt;
        base_q <= '0;
      end
    end else if (advance) begin
      rem_q  <= rem_q - CNT_W'(num);
      base_q <= base_q + CNT_W'(num);
      if (int'(rem_q) <= NSLOT) st_q <= SQ_IDLE;
    end
  end
endmodule

// File: rtl/asym_decoder.sv
module asym_decoder #(
  parameter int NSLOT = 4,
  parameter int MAXC  = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter int LEN_W = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(NSLOT+1)-1:0]          in_cnt,
  input  logic [NSLOT*TAG_W-1:0]              in_tag,
  input  logic [NSLOT*CNT_W-1:0]              in_nuop,
  input  logic [NSLOT*LEN_W-1:0]              in_len,
  output logic [$clog2(NSLOT+1)-1:0]          take_cnt,
  output logic [LEN_W+$clog2(NSLOT)-1:0]      take_bytes,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [$clog2(NSLOT+1)-1:0]          out_num,
  output logic [NSLOT*TAG_W-1:0]              out_tag,
  output logic [NSLOT*CNT_W-1:0]              out_sub
);
  localparam int LCW    = $clog2(NSLOT+1);
  localparam int BYTE_W = LEN_W + $clog2(NSLOT);

  logic              divert, fire, load, seq_busy;
  logic [LCW-1:0]    grp_uops, grp_insts, seq_num;
  logic [BYTE_W-1:0] grp_bytes;
  logic [TAG_W-1:0]  seq_tag;
  logic [CNT_W-1:0]  seq_base, seq_rem;

  asd_steer #(.NSLOT(NSLOT), .MAXC(MAXC), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_steer (
    .enable    (!seq_busy),
    .avail     (in_cnt),
    .nuop      (in_nuop),
    .len       (in_len),
    .divert    (divert),
    .grp_uops  (grp_uops),
    .grp_insts (grp_insts),
    .grp_bytes (grp_bytes)
  );

  assign out_valid = seq_busy | (grp_insts != '0);
  assign out_num   = seq_busy ? seq_num : grp_uops;
  assign fire      = out_valid & out_ready;
  assign load      = divert & out_ready;

  asd_useq #(.NSLOT(NSLOT), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_useq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_tag (in_tag[TAG_W-1:0]),
    .load_cnt (in_nuop[CNT_W-1:0]),
    .advance  (fire),
    .busy     (seq_busy),
    .tag      (seq_tag),
    .base     (seq_base),
    .rem      (seq_rem),
    .num      (seq_num)
  );

  asd_lanes #(.NSLOT(NSLOT), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_lanes (
    .seq_busy (seq_busy),
    .seq_tag  (seq_tag),
    .seq_base (seq_base),
    .num      (out_num),
    .lead     (in_nuop[CNT_W-1:0]),
    .in_tag   (in_tag),
    .lane_tag (out_tag),
    .lane_sub (out_sub)
  );

  always_comb begin
    take_cnt   = '0;
    take_bytes = '0;
    if (fire && !seq_busy) begin
      take_cnt   = grp_insts;
      take_bytes = grp_bytes;
    end else if (load) begin
      take_cnt   = LCW'(1);
      take_bytes = {{(BYTE_W-LEN_W){1'b0}}, in_len[LEN_W-1:0]};
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(seq_busy) && $stable(seq_rem) && $stable(seq_base));

  // R7
  seq_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (take_cnt == '0) && out_valid);

  // R4
  uop_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_num != '0) && (int'(out_num) <= NSLOT));

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(take_cnt) == LCW'(1) && $past(!out_valid));
endmodule

// File: tb/test_asym_decoder.sv
module test_asym_decoder;
  localparam int NP = 360;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  in_cnt;
  logic [31:0] in_tag;
  logic [15:0] in_nuop;
  logic [15:0] in_len;
  logic [2:0]  take_cnt;
  logic [5:0]  take_bytes;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_num;
  logic [31:0] out_tag;
  logic [15:0] out_sub;

  always #10 clk = ~clk;

  asym_decoder i_asym_decoder (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_tag(in_tag),
    .in_nuop(in_nuop), .in_len(in_len), .take_cnt(take_cnt),
    .take_bytes(take_bytes), .out_valid(out_valid), .out_ready(out_ready),
    .out_num(out_num), .out_tag(out_tag), .out_sub(out_sub)
  );

  int p_nu[NP];
  int p_ln[NP];
  int np_fill;
  int head, m_busy, m_tag, m_rem, m_base;
  int n_tests, n_fail, cyc;

  task automatic add(int nu, int ln);
    if (np_fill < NP) begin
      p_nu[np_fill] = nu;
      p_ln[np_fill] = ln;
      np_fill++;
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cyc=%0d: got %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic build();
    np_fill = 0;
    for (int i = 0; i < 8; i++) add(1, i % 15 + 1);
    add(3, 5); add(1, 2); add(1, 3); add(1, 4);
    add(1, 7); add(2, 6); add(1, 1);
    add(4, 15); add(1, 1);
    add(9, 3); add(1, 2);
    add(15, 14); add(5, 1); add(2, 2); add(1, 1); add(1, 1); add(1, 1);
    while (np_fill < NP) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 60) add(1, $urandom_range(1, 15));
      else if (r < 85) add($urandom_range(2, 4), $urandom_range(1, 15));
      else add($urandom_range(5, 15), $urandom_range(1, 15));
    end
  endtask

  task automatic drive();
    int av;
    av = (NP - head < 4) ? NP - head : 4;
    in_cnt = 3'(av);
    in_tag = '0; in_nuop = '0; in_len = '0;
    for (int i = 0; i < av; i++) begin
      in_tag[i*8 +: 8]  = 8'(head + i);
      in_nuop[i*4 +: 4] = 4'(p_nu[head + i]);
      in_len[i*4 +: 4]  = 4'(p_ln[head + i]);
    end
  endtask

  task automatic step();
    int av, ev, en, et, eb, ni, div, stop_multi;
    int e_tag[4];
    int e_sub[4];
    string rq;
    av = int'(in_cnt);
    ev = 0; en = 0; et = 0; eb = 0; ni = 0; div = 0; stop_multi = 0;
    for (int l = 0; l < 4; l++) begin e_tag[l] = 0; e_sub[l] = 0; end
    if (m_busy != 0) begin
      ev = 1;
      en = (m_rem > 4) ? 4 : m_rem;
      for (int l = 0; l < en; l++) begin
        e_tag[l] = m_tag & 255;
        e_sub[l] = m_base + l;
      end
    end else if (av > 0) begin
      if (p_nu[head] > 4) begin
        div = 1;
        if (out_ready) begin et = 1; eb = p_ln[head]; end
      end else begin
        ev = 1;
        for (int u = 0; u < p_nu[head]; u++) begin
          e_tag[en] = head & 255; e_sub[en] = u; en++;
        end
        eb = p_ln[head]; ni = 1;
        for (int k = 1; k < av; k++) begin
          if (p_nu[head + k] != 1) begin stop_multi = 1; break; end
          if (en >= 4) break;
          e_tag[en] = (head + k) & 255; e_sub[en] = 0; en++;
          eb += p_ln[head + k]; ni++;
        end
        if (out_ready) et = ni; else eb = 0;
      end
    end
    if (ev == 0) eb = (div != 0 && out_ready) ? eb : 0;

    rq = (m_busy != 0) ? "R7" : (div != 0) ? "R6" : (av == 0) ? "R10" : "R4";
    chk(rq, "out_valid", int'(out_valid), ev);
    if (ev != 0) chk(rq, "out_num", int'(out_num), en);
    for (int l = 0; l < 4; l++) begin
      string lr;
      lr = (m_busy != 0) ? "R7" : (l < ((av > 0) ? p_nu[head] : 0)) ? "R2" : "R5";
      chk(lr, $sformatf("lane%0d tag", l), int'(out_tag[l*8 +: 8]), e_tag[l]);
      chk(lr, $sformatf("lane%0d sub", l), int'(out_sub[l*4 +: 4]), e_sub[l]);
    end
    rq = (!out_ready) ? "R8" : (m_busy != 0) ? "R7" : (div != 0) ? "R6" :
         (stop_multi != 0) ? "R3" : "R9";
    chk(rq, "take_cnt", int'(take_cnt), et);
    chk((!out_ready) ? "R8" : "R9", "take_bytes", int'(take_bytes), eb);

    if (out_ready) begin
      if (m_busy != 0) begin
        m_rem -= en; m_base += en;
        if (m_rem == 0) m_busy = 0;
      end else if (div != 0) begin
        m_busy = 1; m_tag = head; m_rem = p_nu[head]; m_base = 0; head++;
      end else if (ev != 0) begin
        head += ni;
      end
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0;
    head = 0; m_busy = 0; m_tag = 0; m_rem = 0; m_base = 0;
    build();
    rst_n = 1'b0; out_ready = 1'b1;
    in_cnt = '0; in_tag = '0; in_nuop = '0; in_len = '0;
    repeat (3) @(negedge clk);
    #5;
    chk("R1", "reset out_valid", int'(out_valid), 0);
    chk("R1", "reset take_cnt", int'(take_cnt), 0);
    chk("R1", "reset take_bytes", int'(take_bytes), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", "post-reset out_valid", int'(out_valid), 0);
    while ((head < NP || m_busy != 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc < 60) ? (cyc % 7 != 3) : ($urandom_range(0, 9) < 7);
      drive();
      #5;
      step();
    end
    if (cyc >= 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, 20000);
    end
    @(negedge clk);
    in_cnt = '0; out_ready = 1'b1;
    #5;
    chk("R10", "empty window out_valid", int'(out_valid), 0);
    chk("R10", "empty window take_cnt", int'(take_cnt), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule